// File: doc/BRIEF.md
# Iterative Feistel Block Cipher Engine (TEA family)

This block encrypts or decrypts a single 64-bit block under a 128-bit key. It does so over many clock cycles with one shared datapath. The block is split into two 32-bit words, and each word in turn is mixed with a value built from the other word, a running sum and one of four key words. A small state machine performs one half-round per clock. A 32-bit sum register advances by the round constant between the two halves of each cycle.

The caller places the data words, the four key words and the direction bit on the inputs, then pulses `start`. After the fixed latency, `done` pulses for one clock. The result then stays on `dout` until the next accepted start. The same hardware does decryption: it steps the sum backwards and applies the two half-rounds in reverse order. A start seen while a block is in flight has no effect.

Top module: `tea_iter_core`

## Requirements
- R1: After reset, `done` is 0 and `dout` is all zeros.
- R2: Word conventions. On start, `din_hi` is the first word v0 and `din_lo` is the second word v1. The result is `dout = {v0, v1}`, and the key words are indexed so that index n selects `key<n>`.
- R3: Encryption performs 32 cycles, starting with sum = 0. In each cycle: first v0 += (((v1<<4) ^ (v1>>5)) + v1) ^ (sum + key[sum[1:0]]); then sum += 0x9E3779B9; then v1 += (((v0<<4) ^ (v0>>5)) + v0) ^ (sum + key[sum[12:11]]).
- R4: Decryption starts with sum = 0xC6EF3720 and undoes R3 exactly, in reverse order. Decrypting any ciphertext under the same key returns the original plaintext.
- R5: All additions and subtractions wrap modulo 2^32.
- R6: The sum changes by exactly 0x9E3779B9 once per cycle, upward when encrypting and downward when decrypting. When done is raised, the sum equals 0xC6EF3720 after encryption and 0 after decryption.
- R7: `done` rises 64 clock edges after the edge that accepted `start`.
- R8: `done` is high for exactly one clock. `dout` stays unchanged until the next accepted start.
- R9: A `start` asserted while a block is being processed is ignored. It changes neither the result nor the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block when idle |
| mode_dec | input | 1 | 1 = decrypt, 0 = encrypt; sampled with start |
| din_hi | input | 32 | First data word (v0) |
| din_lo | input | 32 | Second data word (v1) |
| key0 | input | 32 | Key word, index 0 |
| key1 | input | 32 | Key word, index 1 |
| key2 | input | 32 | Key word, index 2 |
| key3 | input | 32 | Key word, index 3 |
| dout | output | 64 | Result {v0, v1} |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps a set of keys and blocks generated by arithmetic. It includes the all-zero and all-ones cases, which stress wrap-around, and it compares each result against a software model. The model catches several errors: a swapped key index between the two half-rounds gives a wrong ciphertext whenever the key words differ, and a sum updated at the wrong point or in the wrong direction breaks the round trip through decryption. An off-by-one termination shows up as a latency other than 64 and a wrong result. A start pulse injected mid-operation with a different direction and different data catches an engine that restarts while busy: such an engine reports a late or corrupted result.

// File: rtl/tea_pkg.sv
package tea_pkg;
    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_SECOND = 2'd2
    } tea_state_e;

    typedef struct packed {
        tea_state_e state;
        logic       dec;
        word_t      v0;
        word_t      v1;
        word_t      sum;
        logic       done;
    } tea_regs_t;
endpackage

// File: rtl/tea_round_fn.sv
module tea_round_fn
    import tea_pkg::*;
#(
    parameter int unsigned SHL = 4,
    parameter int unsigned SHR = 5
) (
    input  word_t x,
    input  word_t salt,
    output word_t mix
);
    word_t spread;

    always_comb begin
        spread = (x << SHL) ^ (x >> SHR);
        mix    = (spread + x) ^ salt;
    end
endmodule

// File: rtl/tea_key_sel.sv
module tea_key_sel
    import tea_pkg::*;
#(
    parameter int unsigned KSHIFT = 11
) (
    input  word_t                   sum,
    input  logic                    use_hi,
    input  logic [3:0][WORD_W-1:0]  keys,
    output word_t                   salt
);
    logic [1:0] idx;

    always_comb begin
        idx  = use_hi ? sum[KSHIFT +: 2] : sum[1:0];
        salt = sum + keys[idx];
    end
endmodule

// File: rtl/tea_sum_step.sv
module tea_sum_step
    import tea_pkg::*;
#(
    parameter word_t DELTA = 32'h9E37_79B9
) (
    input  word_t sum,
    input  logic  dec,
    output word_t sum_nx
);
    always_comb begin
        sum_nx = dec ? (sum - DELTA) : (sum + DELTA);
    end
endmodule

// File: rtl/tea_iter_core.sv
module tea_iter_core
    import tea_pkg::*;
#(
    parameter int unsigned CYCLES = 32,
    parameter logic [31:0] DELTA  = 32'h9E37_79B9,
    parameter int unsigned SHL    = 4,
    parameter int unsigned SHR    = 5,
    parameter int unsigned KSHIFT = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        mode_dec,
    input  logic [31:0] din_hi,
    input  logic [31:0] din_lo,
    input  logic [31:0] key0,
    input  logic [31:0] key1,
    input  logic [31:0] key2,
    input  logic [31:0] key3,
    output logic [63:0] dout,
    output logic        done
);
    localparam logic [63:0] LIMIT_W = 64'(DELTA) * 64'(CYCLES);
    localparam word_t       LIMIT   = LIMIT_W[WORD_W-1:0];

    tea_regs_t r_q, r_d;

    logic                   upd_v0;
    logic                   ld_v0, ld_v1, ld_sum;
    word_t                  operand, target, salt, mix, upd_val, sum_nx;
    logic [3:0][WORD_W-1:0] key_arr;

    assign key_arr = {key3, key2, key1, key0};

    // Which word is rewritten this half-round: the first state of an
    // encrypt cycle and the second state of a decrypt cycle touch v0.
    always_comb begin
        upd_v0  = (r_q.state == ST_FIRST) ^ r_q.dec;
        operand = upd_v0 ? r_q.v1 : r_q.v0;
        target  = upd_v0 ? r_q.v0 : r_q.v1;
        upd_val = r_q.dec ? (target - mix) : (target + mix);
    end

    tea_key_sel #(.KSHIFT(KSHIFT)) u_key_sel (
        .sum    (r_q.sum),
        .use_hi (~upd_v0),
        .keys   (key_arr),
        .salt   (salt)
    );

    tea_round_fn #(.SHL(SHL), .SHR(SHR)) u_round_fn (
        .x    (operand),
        .salt (salt),
        .mix  (mix)
    );

    tea_sum_step #(.DELTA(DELTA)) u_sum_step (
        .sum    (r_q.sum),
        .dec    (r_q.dec),
        .sum_nx (sum_nx)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ld_v0    = 1'b0;
        ld_v1    = 1'b0;
        ld_sum   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_FIRST;
                    r_d.dec   = mode_dec;
                    r_d.v0    = din_hi;
                    r_d.v1    = din_lo;
                    r_d.sum   = mode_dec ? LIMIT : '0;
                end
            end
            ST_FIRST: begin
                ld_v0     = upd_v0;
                ld_v1     = ~upd_v0;
                ld_sum    = 1'b1;
                r_d.state = ST_SECOND;
            end
            ST_SECOND: begin
                ld_v0 = upd_v0;
                ld_v1 = ~upd_v0;
                if (r_q.sum == (r_q.dec ? word_t'(0) : LIMIT)) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.state = ST_FIRST;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (ld_v0)  r_d.v0  = upd_val;
        if (ld_v1)  r_d.v1  = upd_val;
        if (ld_sum) r_d.sum = sum_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, dec: 1'b0, v0: '0, v1: '0, sum: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign dout = {r_q.v0, r_q.v1};
    assign done = r_q.done;
endmodule

// File: rtl/tea_iter_core_chk.sv
module tea_iter_core_chk
    import tea_pkg::*;
#(
    parameter int unsigned CYCLES = 32,
    parameter logic [31:0] DELTA  = 32'h9E37_79B9
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        done,
    input logic [63:0] dout,
    input tea_state_e  state,
    input logic        dec,
    input word_t       sum
);
    localparam logic [63:0] LIMIT_W = 64'(DELTA) * 64'(CYCLES);
    localparam word_t       LIMIT   = LIMIT_W[WORD_W-1:0];

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(dout));

    a_r6_end_sum: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dec ? (sum == '0) : (sum == LIMIT)));

    a_r6_sum_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST) |=> (dec ? (($past(sum) - sum) == DELTA)
                                     : ((sum - $past(sum)) == DELTA)));

    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> ($stable(dec) && state != ST_FIRST || $past(state) == ST_SECOND));
endmodule

bind tea_iter_core tea_iter_core_chk #(.CYCLES(CYCLES), .DELTA(DELTA)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .done  (done),
    .dout  (dout),
    .state (r_q.state),
    .dec   (r_q.dec),
    .sum   (r_q.sum)
);

// File: tb/tea_iter_core_tb_top.sv
module tea_iter_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_dec = 1'b0;
    logic [31:0] din_hi = '0, din_lo = '0;
    logic [31:0] key0 = '0, key1 = '0, key2 = '0, key3 = '0;
    logic [63:0] dout;
    logic        done;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] DLT = 32'h9E37_79B9;

    always #2.5 clk = ~clk;

    tea_iter_core dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_dec(mode_dec),
        .din_hi(din_hi), .din_lo(din_lo),
        .key0(key0), .key1(key1), .key2(key2), .key3(key3),
        .dout(dout), .done(done)
    );

    function automatic logic [31:0] mixf(input logic [31:0] x, input logic [31:0] s);
        return (((x << 4) ^ (x >> 5)) + x) ^ s;
    endfunction

    function automatic logic [63:0] model(input bit dec, input logic [63:0] blk,
                                          input logic [127:0] k);
        logic [31:0] v0, v1, s;
        logic [31:0] kw [4];
        v0 = blk[63:32]; v1 = blk[31:0];
        for (int n = 0; n < 4; n++) kw[n] = k[32*n +: 32];
        s = dec ? 32'hC6EF_3720 : 32'h0;
        for (int c = 0; c < 32; c++) begin
            if (!dec) begin
                v0 = v0 + mixf(v1, s + kw[s[1:0]]);
                s  = s + DLT;
                v1 = v1 + mixf(v0, s + kw[s[12:11]]);
            end else begin
                v1 = v1 - mixf(v0, s + kw[s[12:11]]);
                s  = s - DLT;
                v0 = v0 - mixf(v1, s + kw[s[1:0]]);
            end
        end
        return {v0, v1};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Runs one block; inj > 0 pulses a conflicting start at that cycle.
    task automatic run_op(input bit dec, input logic [63:0] blk, input logic [127:0] k,
                          input int inj, output logic [63:0] res, output int lat);
        @(negedge clk);
        start = 1'b1; mode_dec = dec;
        din_hi = blk[63:32]; din_lo = blk[31:0];
        {key3, key2, key1, key0} = k;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
            start = (lat == inj);
            if (lat == inj) begin
                mode_dec = ~dec; din_hi = ~din_hi; din_lo = din_lo ^ 32'h5A5A_5A5A;
            end
        end
        start = 1'b0;
        res = dout;
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", {63'b0, done}, 64'd0);
        chk(dout == res, "R8 result held", dout, res);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0]  blk, ct, pt, exp;
        logic [127:0] k;
        logic [31:0]  seed;
        int           lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout == 64'd0, "R1 reset result", dout, 64'd0);
        chk(done == 1'b0, "R1 reset done", {63'b0, done}, 64'd0);

        seed = 32'h1234_5678;
        for (int i = 0; i < 14; i++) begin
            if (i == 0) begin
                blk = '0; k = '0;
            end else if (i == 1) begin
                blk = '1; k = '1;
            end else begin
                for (int w = 0; w < 6; w++) begin
                    seed = seed * 32'd1664525 + 32'd1013904223;
                    if (w < 2) blk[32*w +: 32] = seed;
                    else       k[32*(w-2) +: 32] = seed;
                end
            end
            exp = model(1'b0, blk, k);
            run_op(1'b0, blk, k, 0, ct, lat);
            chk(ct == exp, "R2 R3 R5 encrypt vs model", ct, exp);
            chk(lat == 64, "R7 encrypt latency", 64'(lat), 64'd64);
            run_op(1'b1, ct, k, 0, pt, lat);
            chk(pt == blk, "R4 decrypt round trip", pt, blk);
            chk(lat == 64, "R7 decrypt latency", 64'(lat), 64'd64);
            chk(model(1'b1, ct, k) == blk, "R4 model self", model(1'b1, ct, k), blk);
        end

        // R9: start while busy, encrypt then decrypt directions
        blk = 64'h0123_4567_89AB_CDEF;
        k   = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
        exp = model(1'b0, blk, k);
        run_op(1'b0, blk, k, 10, ct, lat);
        chk(ct == exp, "R9 busy start ignored enc", ct, exp);
        chk(lat == 64, "R9 busy latency enc", 64'(lat), 64'd64);
        run_op(1'b1, ct, k, 63, pt, lat);
        chk(pt == blk, "R9 busy start ignored dec", pt, blk);
        chk(lat == 64, "R9 busy latency dec", 64'(lat), 64'd64);

        // R8: result held over idle cycles
        repeat (5) @(negedge clk);
        chk(dout == blk, "R8 hold over idle", dout, blk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule